// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block connects a clocked internal request port to an external asynchronous 16-bit static RAM with an 18-bit address. A request holds an address, write data, a write flag and a two-bit lane mask. The controller accepts it only while idle. It then plays out one read or write on the RAM pins, with every pulse width and setup window counted in clock cycles, and deselects the RAM again at the end.

Writes follow a sequence in which the write-enable strobe controls the timing. First comes a setup cycle with the chip selected and the write data already driven. The write strobe then stays low for a parameterised number of cycles, and a hold cycle follows in which the data is still driven. Output enable stays high for the whole write. Reads select the chip with output enable low for the full access time. The controller captures the enabled lanes on the last clock of the access and returns them with a one-cycle response pulse. One deselected turnaround cycle follows every read, so the RAM has released the bus before the controller can drive it again.

Top module: `sram_lane_ctrl`

## Requirements
- R1: Idle pins. After reset, and whenever `req_ready` is high, the RAM pins are in this state: `sram_ce_n`, `sram_we_n`, `sram_oe_n`, `sram_ub_n` and `sram_lb_n` are all 1, and `sram_dq_oe` is 0. After reset, `rsp_valid` is 0.
- R2: Accept only when idle. A request is accepted on a rising edge where both `req_valid` and `req_ready` are high. `req_ready` is low in the cycle after an accept. A request held valid while the controller is busy is not taken until `req_ready` returns.
- R3: Write strobe timing. A write has three parts: one setup cycle with the chip selected and the write strobe high, then `WE_CYC` cycles with `sram_we_n` low, then one hold cycle. The next request can be accepted `WE_CYC+3` clock edges after the write was accepted.
- R4: Write bus control. While `sram_we_n` is low, `sram_oe_n` is high, `sram_ce_n` is low and `sram_dq_oe` is high with the request's write data on `sram_dq_o`. The data stays driven and unchanged in the hold cycle.
- R5: Stable address. While `sram_ce_n` stays low, `sram_addr`, `sram_ub_n` and `sram_lb_n` do not change.
- R6: Lane mapping. Mask bit 1 selects the upper lane (data bits 15..8, pin `sram_ub_n` driven to 0). Mask bit 0 selects the lower lane (bits 7..0, pin `sram_lb_n` driven to 0). A write stores only the selected lanes.
- R7: Read timing. A read holds `sram_ce_n` and `sram_oe_n` low and `sram_we_n` high for `ACC_CYC` cycles, and samples the bus on the last of those cycles. `rsp_valid` is high for exactly one cycle, `ACC_CYC` edges after the accept edge.
- R8: Masked read lanes. In `rsp_rdata`, a lane not selected by the mask reads as 0x00. A request with mask 00 stores nothing and returns 0x0000.
- R9: Read turnaround. After a read there are `TURN_CYC` deselected cycles. The next request can be accepted `ACC_CYC+TURN_CYC+1` edges after the read was accepted.
- R10: No contention. `sram_dq_oe` is never high while `sram_oe_n` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_bmask | input | 2 | Lane mask, bit 1 upper, bit 0 lower |
| rsp_valid | output | 1 | One-cycle read response strobe |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| sram_addr | output | 18 | RAM address |
| sram_ce_n | output | 1 | RAM chip select, active low |
| sram_we_n | output | 1 | RAM write strobe, active low |
| sram_oe_n | output | 1 | RAM output enable, active low |
| sram_ub_n | output | 1 | Upper lane enable, active low |
| sram_lb_n | output | 1 | Lower lane enable, active low |
| sram_dq_o | output | 16 | Data driven toward the RAM |
| sram_dq_oe | output | 1 | Tri-state enable for `sram_dq_o` |
| sram_dq_i | input | 16 | Data read from the RAM bus |

## Verification
Results are due at fixed points counted from the accept edge. The read response comes `ACC_CYC` edges after the accept. The next accept comes `WE_CYC+3` edges after a write and `ACC_CYC+TURN_CYC+1` edges after a read. `req_ready` drops at the first edge after any accept. The bench keeps a posedge counter. It drives requests and samples every output on falling edges. Each expected response is queued with its due cycle, and a check fails if the response arrives on any other cycle. The bench's RAM model counts falling-edge samples of `sram_oe_n` and `sram_we_n`. It returns corrupted data to a read that samples too early, and it reports a write strobe that is too short, a missing setup or hold cycle, or a change of address or lane enables while the chip is selected.

// File: rtl/sram_lane_pkg.sv
package sram_lane_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WSET  = 3'd1,
    ST_WSTB  = 3'd2,
    ST_WHOLD = 3'd3,
    ST_RACC  = 3'd4,
    ST_RTURN = 3'd5
  } slc_state_e;

  typedef struct packed {
    logic ce_n;
    logic we_n;
    logic oe_n;
    logic dq_oe;
  } slc_ctl_t;

  localparam slc_ctl_t SLC_CTL_IDLE = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1, dq_oe: 1'b0};

endpackage

// File: rtl/slc_reset_sync.sv
module slc_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/slc_cycle_timer.sv
module slc_cycle_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             last
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (cnt_q != '0) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign last = (cnt_q == '0);

endmodule

// File: rtl/slc_lane_datapath.sv
module slc_lane_datapath #(
  parameter int DATA_W = 16,
  parameter int LANES  = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_load,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              capture,
  input  logic [LANES-1:0]  lane_en,
  input  logic [DATA_W-1:0] bus_in,
  output logic [DATA_W-1:0] bus_out,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);

  logic [DATA_W-1:0] wdata_q;
  logic [DATA_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdata_q <= '0;
    end else if (wr_load) begin
      wdata_q <= wr_data;
    end
  end

  // Each lane is captured on its own; an unselected lane is forced to zero.
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rdata_q[g*8 +: 8] <= 8'h00;
      end else if (capture) begin
        rdata_q[g*8 +: 8] <= lane_en[g] ? bus_in[g*8 +: 8] : 8'h00;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture;
    end
  end

  assign bus_out  = wdata_q;
  assign rd_data  = rdata_q;
  assign rd_valid = rvalid_q;

endmodule

// File: rtl/sram_lane_ctrl.sv
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int ADDR_W   = 18,
  parameter int DATA_W   = 16,
  parameter int ACC_CYC  = 6,
  parameter int WE_CYC   = 4,
  parameter int TURN_CYC = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_bmask,
  output logic                  rsp_valid,
  output logic [DATA_W-1:0]     rsp_rdata,
  output logic [ADDR_W-1:0]     sram_addr,
  output logic                  sram_ce_n,
  output logic                  sram_we_n,
  output logic                  sram_oe_n,
  output logic                  sram_ub_n,
  output logic                  sram_lb_n,
  output logic [DATA_W-1:0]     sram_dq_o,
  output logic                  sram_dq_oe,
  input  logic [DATA_W-1:0]     sram_dq_i
);

  localparam int LANES   = DATA_W / 8;
  localparam int MAX_A   = (ACC_CYC > WE_CYC) ? ACC_CYC : WE_CYC;
  localparam int MAX_CYC = (MAX_A > TURN_CYC) ? MAX_A : TURN_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic             rst_n_i;
  slc_state_e       st_q, st_d;
  logic             accept;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_last;
  logic             capture;
  logic [ADDR_W-1:0] addr_q;
  logic [LANES-1:0] mask_q, mask_d;
  slc_ctl_t         ctl_q, ctl_d;
  logic [LANES-1:0] ben_q, ben_d;

  slc_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  slc_cycle_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  slc_lane_datapath #(.DATA_W(DATA_W), .LANES(LANES)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .wr_load  (accept && req_write),
    .wr_data  (req_wdata),
    .capture  (capture),
    .lane_en  (mask_q),
    .bus_in   (sram_dq_i),
    .bus_out  (sram_dq_o),
    .rd_data  (rsp_rdata),
    .rd_valid (rsp_valid)
  );

  // Sequencer next state
  always_comb begin
    accept   = req_valid && (st_q == ST_IDLE);
    st_d     = st_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    capture  = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_write) begin
            st_d = ST_WSET;
          end else begin
            st_d     = ST_RACC;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(ACC_CYC - 1);
          end
        end
      end
      ST_WSET: begin
        st_d     = ST_WSTB;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(WE_CYC - 1);
      end
      ST_WSTB: begin
        if (tmr_last) st_d = ST_WHOLD;
      end
      ST_WHOLD: begin
        st_d = ST_IDLE;
      end
      ST_RACC: begin
        if (tmr_last) begin
          st_d     = ST_RTURN;
          capture  = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(TURN_CYC - 1);
        end
      end
      ST_RTURN: begin
        if (tmr_last) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Pin values are decoded from the next state and registered, so every
  // strobe leaves a flop directly.
  always_comb begin
    mask_d      = accept ? req_bmask : mask_q;
    ctl_d.ce_n  = !((st_d == ST_WSET) || (st_d == ST_WSTB) ||
                    (st_d == ST_WHOLD) || (st_d == ST_RACC));
    ctl_d.we_n  = (st_d != ST_WSTB);
    ctl_d.oe_n  = (st_d != ST_RACC);
    ctl_d.dq_oe = (st_d == ST_WSET) || (st_d == ST_WSTB) || (st_d == ST_WHOLD);
    ben_d       = ctl_d.ce_n ? {LANES{1'b1}} : ~mask_d;
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      st_q   <= ST_IDLE;
      ctl_q  <= SLC_CTL_IDLE;
      ben_q  <= {LANES{1'b1}};
      mask_q <= '0;
    end else begin
      st_q   <= st_d;
      ctl_q  <= ctl_d;
      ben_q  <= ben_d;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      addr_q <= '0;
    end else if (accept) begin
      addr_q <= req_addr;
    end
  end

  assign req_ready  = (st_q == ST_IDLE);
  assign sram_addr  = addr_q;
  assign sram_ce_n  = ctl_q.ce_n;
  assign sram_we_n  = ctl_q.we_n;
  assign sram_oe_n  = ctl_q.oe_n;
  assign sram_dq_oe = ctl_q.dq_oe;
  assign sram_ub_n  = ben_q[LANES-1];
  assign sram_lb_n  = ben_q[0];

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
module sram_lane_ctrl_chk #(
  parameter int ADDR_W = 18,
  parameter int WE_CYC = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_we_n,
  input logic              sram_oe_n,
  input logic              sram_ub_n,
  input logic              sram_lb_n,
  input logic              sram_dq_oe
);

  logic [15:0] we_low_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_low_cnt <= '0;
    end else if (!sram_we_n) begin
      we_low_cnt <= we_low_cnt + 16'd1;
    end else begin
      we_low_cnt <= '0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (sram_ce_n && sram_we_n && sram_oe_n && sram_ub_n && sram_lb_n && !sram_dq_oe));

  p_we_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sram_we_n) |-> (we_low_cnt == 16'(WE_CYC)));

  p_strobe_guard_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_we_n |-> (sram_oe_n && sram_dq_oe && !sram_ce_n));

  p_pins_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sram_ce_n && $past(!sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_ub_n) && $stable(sram_lb_n)));

  p_rsp_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_no_fight_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !sram_oe_n |-> !sram_dq_oe);

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.ADDR_W(ADDR_W), .WE_CYC(WE_CYC)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_we_n  (sram_we_n),
  .sram_oe_n  (sram_oe_n),
  .sram_ub_n  (sram_ub_n),
  .sram_lb_n  (sram_lb_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_lane_ctrl_tb_top.sv
module sram_lane_ctrl_tb_top;

  localparam int ACC    = 6;
  localparam int WEC    = 4;
  localparam int TURN   = 1;
  localparam int RD_MIN = 6;
  localparam int WE_MIN = 4;

  logic        clk;
  logic        rst_n;
  logic        req_valid, req_ready, req_write;
  logic [17:0] req_addr;
  logic [15:0] req_wdata;
  logic [1:0]  req_bmask;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [17:0] sram_addr;
  logic        sram_ce_n, sram_we_n, sram_oe_n, sram_ub_n, sram_lb_n;
  logic [15:0] sram_dq_o;
  logic        sram_dq_oe;
  logic [15:0] sram_dq_i;

  int n_chk  = 0;
  int n_fail = 0;
  int cyc    = 0;

  sram_lane_ctrl #(.ACC_CYC(ACC), .WE_CYC(WEC), .TURN_CYC(TURN)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_bmask(req_bmask),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
    .sram_oe_n(sram_oe_n), .sram_ub_n(sram_ub_n), .sram_lb_n(sram_lb_n),
    .sram_dq_o(sram_dq_o), .sram_dq_oe(sram_dq_oe), .sram_dq_i(sram_dq_i)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (cyc == 20000) begin
      n_fail++;
      $display("FAIL R2 watchdog expired actual=%0d expected=<20000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  // Behavioural RAM model with timing-rule checks, sampled on falling edges
  logic [15:0] sram_arr [0:(1<<18)-1];
  int          oe_cnt, we_cnt;
  logic        prev_ce_n;
  logic [17:0] prev_addr;
  logic [15:0] wd_hold;
  logic [15:0] rd_word;

  always @(negedge clk) begin
    if (!rst_n) begin
      oe_cnt = 0; we_cnt = 0; prev_ce_n = 1'b1; prev_addr = '0;
    end else begin
      if (sram_dq_oe && !sram_oe_n) chk(0, "R10 bus contention", 1, 0);
      if (!sram_ce_n && !prev_ce_n && (sram_addr != prev_addr))
        chk(0, "R5 address moved while selected", 32'(sram_addr), 32'(prev_addr));
      if (!sram_oe_n) oe_cnt++; else oe_cnt = 0;
      if (!sram_we_n) begin
        if (we_cnt == 0 && prev_ce_n) chk(0, "R3 no setup cycle before strobe", 0, 1);
        if (!sram_dq_oe || !sram_oe_n) chk(0, "R4 bus not driven or output enabled in strobe", 32'(sram_dq_oe), 1);
        we_cnt++;
        wd_hold = sram_dq_o;
      end else if (we_cnt > 0) begin
        if (we_cnt < WE_MIN) chk(0, "R3 write strobe too short", we_cnt, WE_MIN);
        if (sram_ce_n || !sram_dq_oe || (sram_dq_o != wd_hold))
          chk(0, "R4 no hold cycle after strobe", 32'(sram_dq_o), 32'(wd_hold));
        if (!sram_lb_n) sram_arr[sram_addr][7:0]  = wd_hold[7:0];
        if (!sram_ub_n) sram_arr[sram_addr][15:8] = wd_hold[15:8];
        we_cnt = 0;
      end
      prev_ce_n = sram_ce_n;
      prev_addr = sram_addr;
    end
    rd_word = sram_arr[sram_addr];
    if (oe_cnt < RD_MIN) rd_word = ~rd_word;
    sram_dq_i[15:8] = (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_ub_n) ? rd_word[15:8] : 8'hA5;
    sram_dq_i[7:0]  = (!sram_ce_n && !sram_oe_n && sram_we_n && !sram_lb_n) ? rd_word[7:0]  : 8'hA5;
  end

  // Scoreboard
  logic [15:0] ref_arr [0:(1<<18)-1];
  logic [15:0] exp_q [$];
  int          due_q [$];
  int          acc_cyc  = 0;
  bit          have_prev = 0;
  bit          prev_wr   = 0;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) begin
        chk(0, "R7 unexpected response", 32'(rsp_rdata), 0);
      end else begin
        logic [15:0] e;
        int          d;
        e = exp_q.pop_front();
        d = due_q.pop_front();
        chk(rsp_rdata == e, "R6 R8 read data", 32'(rsp_rdata), 32'(e));
        chk(cyc == d, "R7 response latency", cyc, d);
      end
    end
  end

  task automatic do_req(input bit wr, input logic [17:0] a, input logic [15:0] d, input logic [1:0] m);
    int gap_exp;
    int prev_acc;
    req_write = wr; req_addr = a; req_wdata = d; req_bmask = m; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    prev_acc = acc_cyc;
    acc_cyc  = cyc + 1;
    if (have_prev) begin
      gap_exp = prev_wr ? (WEC + 3) : (ACC + TURN + 1);
      if (prev_wr) chk(acc_cyc - prev_acc == gap_exp, "R3 write occupancy", acc_cyc - prev_acc, gap_exp);
      else         chk(acc_cyc - prev_acc == gap_exp, "R9 read turnaround", acc_cyc - prev_acc, gap_exp);
    end
    if (wr) begin
      if (m[1]) ref_arr[a][15:8] = d[15:8];
      if (m[0]) ref_arr[a][7:0]  = d[7:0];
    end else begin
      exp_q.push_back({m[1] ? ref_arr[a][15:8] : 8'h00, m[0] ? ref_arr[a][7:0] : 8'h00});
      due_q.push_back(acc_cyc + ACC);
    end
    have_prev = 1; prev_wr = wr;
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R2 busy after accept", 32'(req_ready), 0);
  endtask

  task automatic idle_pins(input string tag);
    chk(sram_ce_n && sram_we_n && sram_oe_n, {tag, " strobes idle"},
        32'({sram_ce_n, sram_we_n, sram_oe_n}), 32'h7);
    chk(sram_ub_n && sram_lb_n, {tag, " lanes idle"}, 32'({sram_ub_n, sram_lb_n}), 32'h3);
    chk(!sram_dq_oe, {tag, " bus released"}, 32'(sram_dq_oe), 0);
    chk(req_ready, {tag, " ready"}, 32'(req_ready), 1);
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0; req_bmask = '0; sram_dq_i = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    idle_pins("R1 reset");
    chk(!rsp_valid, "R1 reset response", 32'(rsp_valid), 0);

    do_req(1, 18'h00010, 16'h1234, 2'b11);
    do_req(0, 18'h00010, 16'h0000, 2'b11);
    do_req(1, 18'h00010, 16'hAB99, 2'b10);
    do_req(0, 18'h00010, 16'h0000, 2'b10);
    do_req(1, 18'h3FFFF, 16'h0F0F, 2'b11);
    do_req(1, 18'h3FFFF, 16'h99C3, 2'b01);
    do_req(0, 18'h3FFFF, 16'h0000, 2'b01);
    do_req(0, 18'h3FFFF, 16'h0000, 2'b11);
    do_req(1, 18'h00010, 16'h0000, 2'b00);
    do_req(0, 18'h00010, 16'h0000, 2'b00);
    do_req(0, 18'h00010, 16'h0000, 2'b11);
    do_req(1, 18'h00000, 16'hFFFF, 2'b11);
    do_req(0, 18'h00000, 16'h0000, 2'b11);

    repeat (12) @(negedge clk);
    chk(exp_q.size() == 0, "R7 all responses delivered", exp_q.size(), 0);
    idle_pins("R1 after traffic");

    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule